// File: doc/BRIEF.md
# Multiply-Accumulate Register Unit

This block is a 64-bit multiply-accumulate engine with its own hidden operand state: two multiplier words (M0, M1) and two queued partial-product words (Q0, Q1). Each decoded instruction arrives as a valid strobe, a 6-bit function code and two 64-bit source operands, here called `srcA` and `srcB`. An instruction can do one of two things. It can load one of the hidden words from `srcA`, or it can run a multiply-add. A multiply-add drives a 64-bit result and also updates the hidden state as a side effect.

There are two multiply-add flavours. The chained multiply-add returns the low word of `M0*srcA + srcB + Q0`. It then forms the next word, `M1*srcA + Q1` plus the carry word of the first sum, and pushes that into the partial-product queue. The feedback multiply-add returns the same low word, but handles state differently. It writes the result back into M0, clears M1 and clears both partial-product words. That lets repeated feedback operations evaluate a running polynomial in one register.

Every instruction takes one clock. The result and its valid flag are registered, and the hidden state changes on the same edge.

Top module: `mulAccUnit`

## Requirements
- R1: After reset M0, M1, Q0, Q1 and `result` are all zero and `resultValid` is low.
- R2: Function codes are 6'b001000 to load M0, 6'b001100 to load M1, 6'b001001 to load Q0, 6'b001111 for the chained multiply-add and 6'b010000 for the feedback multiply-add. Loads take their value from `srcA` and ignore `srcB`.
- R3: The chained multiply-add returns the low 64 bits of M0*srcA + srcB + Q0. For example, M0=5, Q0=0, srcA=7 and srcB=11 gives 46.
- R4: The chained multiply-add leaves M0 and M1 unchanged. It forms the 128-bit sum M1*srcA + Q1 + (upper 64 bits of the 128-bit sum from R3). The low half of that sum goes to Q0 and the high half goes to Q1.
- R5: The feedback multiply-add returns the low 64 bits of M0*srcA + srcB + Q0, wrapping modulo 2^64. For example, M0=5, Q0=13, srcA=7 and srcB=11 gives 59.
- R6: After a feedback multiply-add, M0 holds the value that was returned.
- R7: A feedback multiply-add clears M1, Q0 and Q1.
- R8: Loading Q0 also clears Q1.
- R9: `resultValid` is high for exactly one cycle, in the cycle after a multiply-add strobe, and `result` changes then. Loads never raise `resultValid` and leave `result` unchanged.
- R10: A valid strobe with any other function code changes no state and does not raise `resultValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | An instruction is presented this cycle |
| funcCode | input | 6 | Function code of the instruction |
| srcA | input | 64 | First source operand (load value or multiplier) |
| srcB | input | 64 | Second source operand (addend) |
| result | output | 64 | Last multiply-add result, held between operations |
| resultValid | output | 1 | High for one cycle when `result` carries a new value |

## Verification
Every result is due exactly one clock after its strobe. The bench drives each instruction on a falling edge, drops the strobe on the next falling edge, and samples `result` and `resultValid` at that same moment. It then checks one cycle later that `resultValid` has fallen.

Hidden state is observed only through the ports. Each test first loads known values, then runs chained multiply-adds with `srcA=0` and `srcB=0`. This makes Q0 and then Q1 appear on `result` in the following cycles, which exposes clearing that was missed and loads that should not have happened.

// File: rtl/mulAccPkg.sv
package mulAccPkg;
  localparam int FUNC_W = 6;

  typedef enum logic [FUNC_W-1:0] {
    FN_LD_M0   = 6'b001000,
    FN_LD_Q0   = 6'b001001,
    FN_LD_M1   = 6'b001100,
    FN_MADD    = 6'b001111,
    FN_MADD_FB = 6'b010000
  } funcE;

  typedef struct packed {
    logic ldM0;
    logic ldM1;
    logic ldQ0;
    logic madd;
    logic maddFb;
  } strobeT;
endpackage

// File: rtl/mulAccCtrl.sv
module mulAccCtrl
  import mulAccPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [FUNC_W-1:0] funcCode,
  output strobeT            strb,
  output logic              resultValid
);

  always_comb begin
    strb = '0;
    if (instValid) begin
      case (funcCode)
        FN_LD_M0:   strb.ldM0   = 1'b1;
        FN_LD_M1:   strb.ldM1   = 1'b1;
        FN_LD_Q0:   strb.ldQ0   = 1'b1;
        FN_MADD:    strb.madd   = 1'b1;
        FN_MADD_FB: strb.maddFb = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= strb.madd | strb.maddFb;
  end

  // R9
  valid_after_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    instValid && (funcCode == FN_MADD || funcCode == FN_MADD_FB) |=> resultValid);

  // R9
  valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(instValid));

  // R10
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !(funcCode inside {FN_LD_M0, FN_LD_M1, FN_LD_Q0, FN_MADD, FN_MADD_FB})
    |=> !resultValid);

endmodule

// File: rtl/mulAccDatapath.sv
module mulAccDatapath
  import mulAccPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);
  localparam int WIDE_W  = 2 * DATA_W;
  localparam int WORDS_N = 2;

  logic [DATA_W-1:0] mulQ  [WORDS_N];
  logic [DATA_W-1:0] partQ [WORDS_N];
  logic [DATA_W-1:0] resultQ;
  logic [WIDE_W-1:0] word0Sum;
  logic [WIDE_W-1:0] word1Sum;

  always_comb begin
    word0Sum = WIDE_W'(mulQ[0]) * WIDE_W'(srcA) + WIDE_W'(srcB) + WIDE_W'(partQ[0]);
    word1Sum = WIDE_W'(mulQ[1]) * WIDE_W'(srcA) + WIDE_W'(partQ[1])
             + WIDE_W'(word0Sum[WIDE_W-1:DATA_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS_N; i++) begin
        mulQ[i]  <= '0;
        partQ[i] <= '0;
      end
      resultQ <= '0;
    end else begin
      if (strb.ldM0) mulQ[0] <= srcA;
      if (strb.ldM1) mulQ[1] <= srcA;
      if (strb.ldQ0) begin
        partQ[0] <= srcA;
        partQ[1] <= '0;
      end
      if (strb.madd) begin
        resultQ  <= word0Sum[DATA_W-1:0];
        partQ[0] <= word1Sum[DATA_W-1:0];
        partQ[1] <= word1Sum[WIDE_W-1:DATA_W];
      end
      if (strb.maddFb) begin
        resultQ  <= word0Sum[DATA_W-1:0];
        mulQ[0]  <= word0Sum[DATA_W-1:0];
        mulQ[1]  <= '0;
        for (int i = 0; i < WORDS_N; i++) partQ[i] <= '0;
      end
    end
  end

  assign result = resultQ;

  // R6 R7
  fb_writeback_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.maddFb |=> (mulQ[0] == resultQ) && (mulQ[1] == '0)
                    && (partQ[0] == '0) && (partQ[1] == '0));

  // R8
  q0_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldQ0 |=> (partQ[1] == '0) && (partQ[0] == $past(srcA)));

  // R4
  madd_keeps_mul_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.madd |=> $stable(mulQ[0]) && $stable(mulQ[1]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb == '0 |=> $stable(mulQ[0]) && $stable(mulQ[1]) && $stable(partQ[0])
                   && $stable(partQ[1]) && $stable(resultQ));

  // R9
  load_keeps_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.madd || strb.maddFb) |=> $stable(resultQ));

endmodule

// File: rtl/mulAccUnit.sv
module mulAccUnit
  import mulAccPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [FUNC_W-1:0] funcCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              resultValid
);

  strobeT strb;

  mulAccCtrl ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .instValid   (instValid),
    .funcCode    (funcCode),
    .strb        (strb),
    .resultValid (resultValid)
  );

  mulAccDatapath #(.DATA_W(DATA_W)) dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result)
  );

endmodule

// File: tb/mulAccUnit_test.sv
module mulAccUnit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] F_LD_M0 = 6'b001000;
  localparam logic [5:0] F_LD_M1 = 6'b001100;
  localparam logic [5:0] F_LD_Q0 = 6'b001001;
  localparam logic [5:0] F_MADD  = 6'b001111;
  localparam logic [5:0] F_FB    = 6'b010000;
  localparam logic [63:0] ONES   = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] TOPBIT = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [5:0]  funcCode = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [63:0] result;
  logic        resultValid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  mulAccUnit uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .funcCode(funcCode),
    .srcA(srcA), .srcB(srcB), .result(result), .resultValid(resultValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one instruction for one cycle; returns at the falling edge after the capturing edge.
  task automatic issue(input logic [5:0] fn, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    instValid = 1'b1; funcCode = fn; srcA = a; srcB = b;
    @(negedge clk);
    instValid = 1'b0; funcCode = '0; srcA = '0; srcB = '0;
  endtask

  task automatic madd(input logic [5:0] fn, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] exp, input string tag);
    issue(fn, a, b);
    chk(tag, result, exp);
    chk({tag, " valid"}, {63'd0, resultValid}, 64'd1);
  endtask

  task automatic setState(input logic [63:0] m0, input logic [63:0] m1, input logic [63:0] q0);
    issue(F_LD_M0, m0, '0);
    issue(F_LD_M1, m1, '0);
    issue(F_LD_Q0, q0, '0);
  endtask

  task automatic testReset();
    chk("R1 result in reset", result, '0);
    chk("R1 valid in reset", {63'd0, resultValid}, '0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {63'd0, resultValid}, '0);
    madd(F_MADD, 0, 0, 0, "R1 Q0 zero");
    madd(F_MADD, 0, 0, 0, "R1 Q1 zero");
    madd(F_MADD, 1, 0, 0, "R1 M0 zero");
  endtask

  task automatic testPlain();
    setState(5, 0, 0);
    madd(F_MADD, 7, 11, 46, "R3 5*7+11");
    @(negedge clk);
    chk("R9 valid one cycle", {63'd0, resultValid}, '0);
    issue(F_LD_Q0, 100, 0);
    madd(F_MADD, 7, 11, 146, "R3 with Q0");
  endtask

  task automatic testCarry();
    setState(ONES, 0, ONES);
    madd(F_MADD, ONES, ONES, ONES, "R4 low word max");
    madd(F_MADD, 0, 0, ONES, "R4 carry into Q0");
    madd(F_MADD, 0, 0, 0, "R4 Q1 after carry");
    setState(0, TOPBIT, 0);
    madd(F_MADD, 4, 0, 0, "R4 high product low");
    madd(F_MADD, 0, 0, 0, "R4 Q0 from M1 low");
    madd(F_MADD, 0, 0, 2, "R4 Q1 from M1 high");
  endtask

  task automatic testFeedback();
    setState(5, 0, 13);
    madd(F_FB, 7, 11, 59, "R5 5*7+11+13");
    madd(F_MADD, 1, 0, 59, "R6 M0 written back");
    setState(TOPBIT, 0, 0);
    madd(F_FB, 2, 0, 0, "R5 wrap");
    madd(F_MADD, 1, 5, 5, "R6 M0 wrapped zero");
  endtask

  task automatic testFbClears();
    setState(0, TOPBIT, 0);
    madd(F_MADD, 4, 0, 0, "R7 prime Q1");
    issue(F_LD_M0, 1, 0);
    issue(F_LD_M1, 1, 0);
    madd(F_FB, 2, 0, 2, "R7 feedback");
    madd(F_MADD, 1, 0, 2, "R7 chained after fb");
    madd(F_MADD, 0, 0, 0, "R7 M1 and Q1 cleared");
    madd(F_MADD, 0, 0, 0, "R7 queue empty");
  endtask

  task automatic testQ0Load();
    setState(0, TOPBIT, 0);
    madd(F_MADD, 4, 0, 0, "R8 prime Q1");
    issue(F_LD_Q0, 7, 99);
    madd(F_MADD, 0, 0, 7, "R8 Q0 loaded");
    madd(F_MADD, 0, 0, 0, "R8 Q1 cleared");
  endtask

  task automatic testLoads();
    setState(0, 0, 0);
    madd(F_MADD, 0, 42, 42, "R9 reference result");
    issue(F_LD_M0, 3, 64'h55);
    chk("R9 load no valid", {63'd0, resultValid}, '0);
    chk("R9 load keeps result", result, 42);
    madd(F_MADD, 2, 1, 7, "R2 srcB ignored by load");
  endtask

  task automatic testUnknown();
    setState(9, 0, 0);
    madd(F_MADD, 0, 3, 3, "R10 reference");
    madd(F_MADD, 0, 0, 0, "R10 drain");
    issue(6'b111111, 77, 5);
    chk("R10 no valid 3F", {63'd0, resultValid}, '0);
    chk("R10 result held 3F", result, 0);
    issue(6'b001010, 44, 6);
    chk("R10 no valid 0A", {63'd0, resultValid}, '0);
    issue(6'b001101, 55, 0);
    madd(F_MADD, 1, 0, 9, "R10 M0 and Q0 untouched");
    madd(F_MADD, 0, 0, 0, "R10 M1 untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testPlain();
    testCarry();
    testFeedback();
    testFbClears();
    testQ0Load();
    testLoads();
    testUnknown();
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule